// File: doc/BRIEF.md
# Strided Vector Memory Access Unit

This unit moves one vector between the register file and an on-block memory that is split into sixteen word-interleaved banks. A command gives a starting word address, a stride and an element count, together with a direction flag. The unit walks the addresses `base + i*stride` (modulo the memory size) and starts at most one bank access per cycle. Each bank stays occupied for a fixed eleven-cycle access. When the next element's bank is still occupied, issue holds. Otherwise the stream flows, so strides whose bank footprint covers the latency run at one element per cycle.

For a store, the unit presents the element position it wants, takes the write data from the register side in that same cycle, and commits the data to the bank. For a load, the data comes back after the bank latency and is written to the register side strictly in element order. Every element is labelled with a chunk number and a lane inside the chunk. A count larger than the register capacity of 64 elements is therefore split into full 64-element chunks and then one shorter remainder chunk. A one-cycle completion pulse closes each command.

Top module: `vsu_stride_unit`

## Requirements
- R1: While reset is held, `cmd_ready` is 1 and `st_take`, `wb_valid` and `done` are 0.
- R2: Element i uses word address `(base + i*stride) mod 256`. Its bank is address bits [3:0] and its row is bits [7:4]. A load returns the last value stored at that word.
- R3: A store element is committed in the cycle in which `st_take` is 1. In that cycle `st_chunk`/`st_lane` name the element, and `st_data` is written to its word.
- R4: Once a bank has accepted an access, it cannot accept another until 11 cycles later. When the next element targets an occupied bank, issue stalls until that bank is free.
- R5: At most one access starts per cycle. A unit-stride stream with all banks free starts one element every cycle from the cycle after acceptance.
- R6: Load element i appears on `wb_valid`/`wb_data` exactly 11 cycles after the cycle in which its access started. Elements appear in increasing element order.
- R7: Element i is labelled with lane `i mod 64` and chunk `i / 64`. For example, 527 elements form chunks 0 to 7 of 64 elements and chunk 8 of 15 elements.
- R8: `done` pulses for one cycle. For a load, it pulses in the cycle after the last write-back. For a store, it pulses in the cycle after the last access started. For a zero-length command, it pulses in the cycle after acceptance.
- R9: A stride of zero is accepted, and its elements start 11 cycles apart.
- R10: A command is taken only when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 from acceptance of a non-empty command until its last access (store) or last write-back (load).
- R11: Bank occupancy carries over from one command to the next, so a command that starts right after a store to the same banks waits for them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_base | input | 8 | Word address of element 0 |
| cmd_stride | input | 8 | Word distance between consecutive elements |
| cmd_len | input | 10 | Number of elements |
| cmd_store | input | 1 | 1 = store, 0 = load |
| st_take | output | 1 | Store element committed this cycle |
| st_lane | output | 6 | Lane of the element being stored |
| st_chunk | output | 4 | Chunk of the element being stored |
| st_data | input | 16 | Register data for the named store element |
| wb_valid | output | 1 | Load element written back this cycle |
| wb_lane | output | 6 | Lane of the returned element |
| wb_chunk | output | 4 | Chunk of the returned element |
| wb_data | output | 16 | Returned element data |
| done | output | 1 | Command completion pulse |

## Verification
Inside a load longer than the bank latency, the start of a later element's access falls in the same cycle as the write-back of an earlier element. Likewise, a command that follows a store can stall on banks that the store left occupied. Unit-stride, stride-two, same-bank, zero-stride and long multi-chunk loads provoke these overlaps, along with random back-to-back commands that have no idle gap. Each issue and write-back cycle is judged against a bench-side bank-free-time schedule. The data is judged against a shadow memory.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
  localparam int DW     = 16;
  localparam int AW     = 8;
  localparam int NBANK  = 16;
  localparam int LAT    = 11;
  localparam int VLMAX  = 64;
  localparam int LENW   = 10;

  localparam int BANKW  = $clog2(NBANK);
  localparam int ROWW   = AW - BANKW;
  localparam int LANEW  = $clog2(VLMAX);
  localparam int CHUNKW = LENW - LANEW;

  typedef struct packed {
    logic              last;
    logic [BANKW-1:0]  bank;
    logic [ROWW-1:0]   row;
    logic [CHUNKW-1:0] chunk;
    logic [LANEW-1:0]  lane;
  } ret_tag_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vsu_addr_gen.sv
module vsu_addr_gen #(
  parameter int AW    = 8,
  parameter int LENW  = 10,
  parameter int VLMAX = 64,
  localparam int LANEW  = $clog2(VLMAX),
  localparam int CHUNKW = LENW - LANEW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     stride,
  input  logic [LENW-1:0]   len,
  output logic [AW-1:0]     addr,
  output logic [LANEW-1:0]  lane,
  output logic [CHUNKW-1:0] chunk,
  output logic              last
);
  logic [AW-1:0]     addr_q,   addr_d;
  logic [AW-1:0]     stride_q, stride_d;
  logic [LANEW-1:0]  lane_q,   lane_d;
  logic [CHUNKW-1:0] chunk_q,  chunk_d;
  logic [LENW-1:0]   left_q,   left_d;

  always_comb begin
    addr_d   = addr_q;
    stride_d = stride_q;
    lane_d   = lane_q;
    chunk_d  = chunk_q;
    left_d   = left_q;
    if (load) begin
      addr_d   = base;
      stride_d = stride;
      lane_d   = '0;
      chunk_d  = '0;
      left_d   = len;
    end else if (step) begin
      addr_d = addr_q + stride_q;
      left_d = left_q - 1'b1;
      if (lane_q == LANEW'(VLMAX - 1)) begin
        lane_d  = '0;
        chunk_d = chunk_q + 1'b1;
      end else begin
        lane_d = lane_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
      lane_q   <= '0;
      chunk_q  <= '0;
      left_q   <= '0;
    end else begin
      addr_q   <= addr_d;
      stride_q <= stride_d;
      lane_q   <= lane_d;
      chunk_q  <= chunk_d;
      left_q   <= left_d;
    end
  end

  assign addr  = addr_q;
  assign lane  = lane_q;
  assign chunk = chunk_q;
  assign last  = (left_q == LENW'(1));
endmodule

// File: rtl/vsu_bank_timer.sv
module vsu_bank_timer #(
  parameter int NBANK = 16,
  parameter int LAT   = 11,
  localparam int BANKW = $clog2(NBANK),
  localparam int CNTW  = $clog2(LAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [BANKW-1:0] fire_bank,
  output logic [NBANK-1:0] busy
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CNTW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (fire && (fire_bank == BANKW'(b))) begin
        cnt_d = CNTW'(LAT - 1);
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign busy[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/vsu_ret_pipe.sv
module vsu_ret_pipe #(
  parameter int DEPTH = 11,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_tag,
  output logic         out_valid,
  output logic [W-1:0] out_tag
);
  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     tag_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[DEPTH-2:0], in_valid};
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (in_valid) tag_q[0] <= in_tag;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (vld_q[s-1]) tag_q[s] <= tag_q[s-1];
      end
    end
  end

  assign out_valid = vld_q[DEPTH-1];
  assign out_tag   = tag_q[DEPTH-1];
endmodule

// File: rtl/vsu_bank_mem.sv
module vsu_bank_mem #(
  parameter int DW    = 16,
  parameter int NBANK = 16,
  parameter int ROWW  = 4,
  localparam int BANKW = $clog2(NBANK),
  localparam int ROWS  = 1 << ROWW
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [BANKW-1:0] wr_bank,
  input  logic [ROWW-1:0]  wr_row,
  input  logic [DW-1:0]    wr_data,
  input  logic [BANKW-1:0] rd_bank,
  input  logic [ROWW-1:0]  rd_row,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == BANKW'(b))) cells[wr_row] <= wr_data;
    end

    assign bank_rd[b] = cells[rd_row];
  end

  assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/vsu_stride_unit.sv
module vsu_stride_unit
  import vsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [AW-1:0]     cmd_base,
  input  logic [AW-1:0]     cmd_stride,
  input  logic [LENW-1:0]   cmd_len,
  input  logic              cmd_store,
  output logic              st_take,
  output logic [LANEW-1:0]  st_lane,
  output logic [CHUNKW-1:0] st_chunk,
  input  logic [DW-1:0]     st_data,
  output logic              wb_valid,
  output logic [LANEW-1:0]  wb_lane,
  output logic [CHUNKW-1:0] wb_chunk,
  output logic [DW-1:0]     wb_data,
  output logic              done
);
  seq_state_e state_q, state_d;
  logic       store_q, store_d;
  logic       done_q,  done_d;

  logic              accept;
  logic              fire;
  logic [AW-1:0]     ag_addr;
  logic [LANEW-1:0]  ag_lane;
  logic [CHUNKW-1:0] ag_chunk;
  logic              ag_last;
  logic [BANKW-1:0]  cur_bank;
  logic [ROWW-1:0]   cur_row;
  logic [NBANK-1:0]  bank_busy;
  ret_tag_t          in_tag, out_tag;
  logic              out_valid;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign cur_bank  = ag_addr[BANKW-1:0];
  assign cur_row   = ag_addr[AW-1:BANKW];
  assign fire      = (state_q == ST_ISSUE) && !bank_busy[cur_bank];

  vsu_addr_gen #(.AW(AW), .LENW(LENW), .VLMAX(VLMAX)) u_agen (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept && (cmd_len != '0)),
    .step   (fire),
    .base   (cmd_base),
    .stride (cmd_stride),
    .len    (cmd_len),
    .addr   (ag_addr),
    .lane   (ag_lane),
    .chunk  (ag_chunk),
    .last   (ag_last)
  );

  vsu_bank_timer #(.NBANK(NBANK), .LAT(LAT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .fire_bank (cur_bank),
    .busy      (bank_busy)
  );

  always_comb begin
    in_tag.last  = ag_last;
    in_tag.bank  = cur_bank;
    in_tag.row   = cur_row;
    in_tag.chunk = ag_chunk;
    in_tag.lane  = ag_lane;
  end

  vsu_ret_pipe #(.DEPTH(LAT), .W($bits(ret_tag_t))) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (fire && !store_q),
    .in_tag    (in_tag),
    .out_valid (out_valid),
    .out_tag   (out_tag)
  );

  vsu_bank_mem #(.DW(DW), .NBANK(NBANK), .ROWW(ROWW)) u_mem (
    .clk     (clk),
    .wr_en   (fire && store_q),
    .wr_bank (cur_bank),
    .wr_row  (cur_row),
    .wr_data (st_data),
    .rd_bank (out_tag.bank),
    .rd_row  (out_tag.row),
    .rd_data (wb_data)
  );

  always_comb begin
    state_d = state_q;
    store_d = store_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          store_d = cmd_store;
          if (cmd_len == '0) done_d  = 1'b1;
          else               state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (fire && ag_last) begin
          if (store_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (out_valid && out_tag.last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      store_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      store_q <= store_d;
      done_q  <= done_d;
    end
  end

  assign st_take  = fire && store_q;
  assign st_lane  = ag_lane;
  assign st_chunk = ag_chunk;
  assign wb_valid = out_valid;
  assign wb_lane  = out_tag.lane;
  assign wb_chunk = out_tag.chunk;
  assign done     = done_q;
endmodule

// File: rtl/vsu_chk.sv
module vsu_chk
  import vsu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              st_take,
  input logic              wb_valid,
  input logic [LANEW-1:0]  wb_lane,
  input logic [CHUNKW-1:0] wb_chunk,
  input logic              iss_fire,
  input logic [BANKW-1:0]  iss_bank
);
  localparam int CNTW = $clog2(LAT);

  logic [LENW-1:0] exp_idx;
  logic [CNTW-1:0] gap [NBANK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      exp_idx <= '0;
    else if (cmd_valid && cmd_ready) exp_idx <= '0;
    else if (wb_valid)               exp_idx <= exp_idx + 1'b1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_gap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     gap[b] <= '0;
      else if (iss_fire && (iss_bank == BANKW'(b)))   gap[b] <= CNTW'(LAT - 1);
      else if (gap[b] != '0)                          gap[b] <= gap[b] - 1'b1;
    end
  end

  // R6
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ({wb_chunk, wb_lane} == exp_idx));

  // R4
  bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |-> (gap[iss_bank] == '0));

  // R10
  wb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !cmd_ready);

  // R3
  st_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_take |-> (!wb_valid && !cmd_ready));

  // R5
  one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |-> !cmd_ready);
endmodule

bind vsu_stride_unit vsu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .st_take   (st_take),
  .wb_valid  (wb_valid),
  .wb_lane   (wb_lane),
  .wb_chunk  (wb_chunk),
  .iss_fire  (fire),
  .iss_bank  (cur_bank)
);

// File: tb/tb_vsu_stride_unit.sv
module tb_vsu_stride_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LAT   = 11;
  localparam int NB    = 16;
  localparam int VL    = 64;
  localparam int MEMW  = 256;
  localparam int WDOG  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_base = '0;
  logic [7:0]  cmd_stride = '0;
  logic [9:0]  cmd_len = '0;
  logic        cmd_store = 1'b0;
  logic        st_take;
  logic [5:0]  st_lane;
  logic [3:0]  st_chunk;
  logic [15:0] st_data;
  logic        wb_valid;
  logic [5:0]  wb_lane;
  logic [3:0]  wb_chunk;
  logic [15:0] wb_data;
  logic        done;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int cur_cmd = 0;
  int bfree [NB];
  logic [15:0] shadow [MEMW];
  int exp_e [1024];
  int exp_a [1024];

  vsu_stride_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_len(cmd_len),
    .cmd_store(cmd_store), .st_take(st_take), .st_lane(st_lane),
    .st_chunk(st_chunk), .st_data(st_data), .wb_valid(wb_valid),
    .wb_lane(wb_lane), .wb_chunk(wb_chunk), .wb_data(wb_data), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] pat(input int c, input int k);
    return 16'((c * 7919 + k * 31 + 5) & 16'hFFFF);
  endfunction

  assign st_data = pat(cur_cmd, int'(st_chunk) * VL + int'(st_lane));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic run_cmd(input int base, input int stride, input int len,
                         input bit store, input string req);
    int a0, prev, e, b, a, exp_done, limit, cnt, idx;
    bit seen;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cur_cmd++;
    cmd_base   = 8'(base);
    cmd_stride = 8'(stride);
    cmd_len    = 10'(len);
    cmd_store  = store;
    cmd_valid  = 1'b1;
    @(negedge clk);
    a0 = cyc;
    cmd_valid = 1'b0;
    prev = a0;
    for (int k = 0; k < len; k++) begin
      a = (base + k * stride) % MEMW;
      b = a % NB;
      e = prev + 1;
      if (bfree[b] > e) e = bfree[b];
      bfree[b] = e + LAT;
      exp_e[k] = e;
      exp_a[k] = a;
      prev = e;
    end
    if (len == 0)   exp_done = a0;
    else if (store) exp_done = exp_e[len-1];
    else            exp_done = exp_e[len-1] + LAT;
    if (len > 0) chk(cmd_ready == 1'b0, "R10 ready low while busy", cmd_ready, 0);
    limit = a0 + len * LAT + 40;
    cnt = 0;
    seen = 0;
    while (!seen && cyc < limit) begin
      if (st_take) begin
        idx = int'(st_chunk) * VL + int'(st_lane);
        if (!store || cnt >= len) chk(0, "R3 unexpected store take", idx, -1);
        else begin
          chk(idx == cnt, "R7 store element label", idx, cnt);
          chk(cyc == exp_e[cnt] - 1, {req, " store issue cycle"}, cyc, exp_e[cnt] - 1);
          shadow[exp_a[cnt]] = pat(cur_cmd, cnt);
          cnt++;
        end
      end
      if (wb_valid) begin
        idx = int'(wb_chunk) * VL + int'(wb_lane);
        if (store || cnt >= len) chk(0, "R6 unexpected write-back", idx, -1);
        else begin
          chk(idx == cnt, "R6 R7 write-back order/label", idx, cnt);
          chk(cyc == exp_e[cnt] + LAT - 1, {req, " R6 write-back cycle"}, cyc, exp_e[cnt] + LAT - 1);
          chk(wb_data === shadow[exp_a[cnt]], "R2 R3 load data", wb_data, shadow[exp_a[cnt]]);
          cnt++;
        end
      end
      if (done) begin
        seen = 1;
        chk(cyc == exp_done, "R8 done cycle", cyc, exp_done);
        chk(cnt == len, "R8 element count at done", cnt, len);
      end
      if (!seen) @(negedge clk);
    end
    if (!seen) chk(0, "R8 done missing", 0, 1);
  endtask

  initial begin
    wait (cyc >= WDOG);
    fails++;
    $display("FAIL R8 watchdog expired, actual=%0d expected<%0d", cyc, WDOG);
    summary();
  end

  initial begin
    int base, stride, len;
    bit st;
    void'($urandom(32'd4242));
    for (int i = 0; i < NB; i++) bfree[i] = 0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 reset cmd_ready", cmd_ready, 1);
    chk(st_take == 1'b0, "R1 reset st_take", st_take, 0);
    chk(wb_valid == 1'b0, "R1 reset wb_valid", wb_valid, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    rst_n = 1'b1;

    run_cmd(0, 1, 256, 1'b1, "R3 R5");
    run_cmd(0, 1, 20, 1'b0, "R5");
    run_cmd(5, 0, 4, 1'b0, "R9");
    run_cmd(3, 2, 20, 1'b0, "R4");
    run_cmd(7, 16, 3, 1'b1, "R4");
    run_cmd(7, 16, 3, 1'b0, "R11");
    run_cmd(9, 1, 527, 1'b0, "R7");
    run_cmd(0, 1, 0, 1'b0, "R8");
    run_cmd(100, 3, 40, 1'b1, "R3");
    run_cmd(100, 3, 40, 1'b0, "R2");
    run_cmd(250, 5, 30, 1'b0, "R2");

    for (int n = 0; n < 30; n++) begin
      base   = int'($urandom % MEMW);
      stride = ($urandom % 4 == 0) ? int'($urandom % 3) * 8 : int'($urandom % MEMW);
      len    = int'($urandom % 150);
      st     = 1'($urandom % 2);
      run_cmd(base, stride, len, st, "R4");
    end

    repeat (2) @(negedge clk);
    summary();
  end
endmodule